// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter. A start request launches a conversion. The block first connects the held analog input to an external integrator for a fixed run of 2^N clocks, using its own counter as the timer. It then switches the integrator over to a reference of the opposite polarity, clears the counter, and counts clocks until an external comparator reports that the integrator output has returned to zero. That count is the conversion result.

The integrator, the comparator and the reference are outside the block. Only three control lines and one comparator line cross the boundary. The analog input must stay constant for the whole conversion. A worst-case conversion takes about 2^(N+1) clocks. After each conversion the block shorts the integrator capacitor for one clock, pulses `done`, and keeps the result steady until the next conversion completes.

Top module: `dslope_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `done`, `sel_ref` and `int_rst` are 0 and `result` is 0.
- R2: A `start` sampled high while idle raises `busy` on the next edge and begins phase I. During phase I, `sel_ref` is 0 (input connected) for exactly 2^N cycles.
- R3: Phase II begins immediately after phase I with `sel_ref` = 1 (reference connected). It ends on the first edge at which `cmp_pos` is 0, where `cmp_pos` = 1 means the integrator is still above zero. `result` is the number of earlier phase II edges at which `cmp_pos` was 1, so `sel_ref` stays high for `result` + 1 cycles.
- R4: If the count reaches 2^N - 1 while `cmp_pos` is still 1, phase II ends on that edge and `result` saturates at 2^N - 1.
- R5: After phase II there is exactly one cycle in which `int_rst` and `done` are both 1 and `sel_ref` is 0. `busy` is still 1 in that cycle and is 0 in the next one.
- R6: `result` changes only on the edge that starts the `done` cycle, and otherwise holds its value.
- R7: A `start` sampled while `busy` is 1 has no effect on the phase lengths or on the result.
- R8: A conversion keeps `busy` high for exactly 2^N + `result` + 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled while idle |
| cmp_pos | input | 1 | Comparator: 1 while the integrator output is above zero |
| sel_ref | output | 1 | 0 connects the input to the integrator, 1 connects the reference |
| int_rst | output | 1 | Shorts the integrator capacitor |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | N | Conversion code |

## Verification
The bench builds the block with N = 4, so phase I lasts 16 cycles and a whole conversion fits in about 35 cycles. This makes it cheap to sweep an ideal integrator model through every input level in quarter-code steps from zero to past full scale. The sweep covers the zero-input case, every rounding step of the trip point, the exact full-scale code and the saturation region. Stray start pulses are injected during phase I and phase II of some conversions to show that they do not change any phase length or the result.

// File: rtl/dslope_seq.sv
module dslope_seq #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         cmp_pos,
  output logic         sel_ref,
  output logic         int_rst,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] result
);
  localparam logic [N-1:0] TOP = {N{1'b1}};

  typedef enum logic [1:0] {IDLE, INTEG, DEINT, CLEAR} phase_t;

  phase_t       ph;
  logic [N-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= IDLE;
      cnt    <= '0;
      result <= '0;
    end else begin
      case (ph)
        IDLE:
          if (start) begin
            ph  <= INTEG;
            cnt <= '0;
          end
        INTEG: begin
          cnt <= cnt + 1'b1;
          if (cnt == TOP) ph <= DEINT;
        end
        DEINT:
          if (!cmp_pos || cnt == TOP) begin
            result <= cnt;
            ph     <= CLEAR;
          end else begin
            cnt <= cnt + 1'b1;
          end
        default: ph <= IDLE;
      endcase
    end
  end

  assign sel_ref = (ph == DEINT);
  assign int_rst = (ph == CLEAR);
  assign done    = (ph == CLEAR);
  assign busy    = (ph != IDLE);

  // R2
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R3
  trip_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ref && !cmp_pos) |=> (done && result == $past(cnt)));

  // R4
  sat_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ref && cnt == TOP) |=> (done && result == TOP));

  // R5
  done_after_deint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(sel_ref) && int_rst && !sel_ref));

  // R5
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

// File: tb/dslope_seq_tb.sv
module dslope_seq_tb_top;
  localparam int N   = 4;
  localparam int TOP = (1 << N) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp_pos;
  logic sel_ref, int_rst, busy, done;
  logic [N-1:0] result;

  int vectors = 0;
  int fails = 0;
  int vin = 0;
  int acc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dslope_seq #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_pos(cmp_pos),
    .sel_ref(sel_ref), .int_rst(int_rst), .busy(busy), .done(done),
    .result(result)
  );

  assign cmp_pos = (acc > 0);

  always @(posedge clk) begin
    if (int_rst) acc <= 0;
    else if (sel_ref) acc <= acc - (4 << N);
    else if (busy) acc <= acc + vin;
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (vin=%0d)", tag, act, exp, vin);
    end
  endtask

  task automatic convert(input int v, input int stray);
    int bcnt = 0, scnt = 0, rcnt = 0, icnt = 0, cyc = 0;
    int exp_r;
    int prev;
    bit over = 0;
    vin = v;
    exp_r = (v + 3) / 4;
    if (exp_r > TOP) exp_r = TOP;
    prev = int'(result);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!over) begin
      cyc++;
      if (stray != 0 && cyc == stray) start = 1'b1;
      else start = 1'b0;
      if (busy) bcnt++;
      if (sel_ref) scnt++;
      if (busy && !sel_ref && !int_rst) icnt++;
      if (int_rst) rcnt++;
      if (done) begin
        chk("R3/R4 result", int'(result), exp_r);
        chk("R5 done with int_rst", int'(int_rst), 1);
        over = 1;
      end else begin
        if (int'(result) != prev) chk("R6 result held", int'(result), prev);
        @(negedge clk);
      end
      if (cyc > 200) over = 1;
    end
    start = 1'b0;
    chk("R2 phase I length", icnt, 1 << N);
    chk("R3 sel_ref length", scnt, exp_r + 1);
    chk("R5 int_rst length", rcnt, 1);
    chk(stray != 0 ? "R7/R8 busy length with stray start" : "R8 busy length",
        bcnt, (1 << N) + exp_r + 2);
    @(negedge clk);
    chk("R5 idle after done", int'(busy), 0);
    chk("R6 result held after done", int'(result), exp_r);
  endtask

  initial begin
    @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 result in reset", int'(result), 0);
    @(negedge clk) rst_n = 1'b1;
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 sel_ref", int'(sel_ref), 0);
    chk("R1 int_rst", int'(int_rst), 0);
    chk("R1 result", int'(result), 0);
    for (int v = 0; v <= (TOP + 4) * 4; v++) begin
      int s;
      s = (v % 5 == 1) ? 3 : ((v % 5 == 3) ? (1 << N) + 2 : 0);
      convert(v, s);
    end
    convert(TOP * 4, (1 << N) + 1);
    convert(0, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule